// File: doc/BRIEF.md
# Supply and Protection Sequencer

This block decides the operating state of an offline switching regulator. It works only from digitized comparator flags: the supply is above the start threshold, the supply is below the lockout threshold, the supply is in overvoltage, the line input is healthy, and the die is too hot. From these flags it drives four controls: the enable of the high-voltage start-up current source, the PWM enable, a one-clock reset for the internal control logic, and a request to actively hold the power switch gate low.

Each flag is asynchronous to the clock and passes through its own two-flop synchronizer. A state machine with five states then sets the outputs:

- charging with the gate clamped,
- the reset pulse,
- run,
- a non-latched fault hold for a line brownout or an over-temperature stop,
- a latched overvoltage stop.

An overvoltage stop is released only when the supply collapses below lockout. Brownout and thermal stops release by themselves when the condition clears. While either of them persists, the supply is discharged to lockout and then recharged, over and over.

Top module: `supply_guard_seq`

## Requirements
- R1: While rst_ni is low, and afterwards while the lockout flag stays high, the outputs are startup_en_o=1, pwm_en_o=0, logic_rst_o=0 and gate_pull_o=1.
- R2: In the charging state, a start flag with the lockout flag low produces exactly one clock of logic_rst_o=1, with pwm_en_o, startup_en_o and gate_pull_o all 0 in that cycle. After that cycle pwm_en_o=1 if no fault is present.
- R3: From any other state, the lockout flag returns the block to charging (startup_en_o=1, gate_pull_o=1, pwm_en_o=0). It stays there until a new start flag arrives.
- R4: The overvoltage flag stops PWM with the start-up source off. This stop holds after the flag clears, and the line and temperature flags do not release it. Only the lockout flag releases it.
- R5: A low line_ok_i stops PWM with the start-up source off. PWM resumes once line_ok_i is high again, with no logic reset pulse.
- R6: A high over_temp_i stops PWM in the same way as R5. PWM resumes without a reset pulse once over_temp_i falls.
- R7: If a brownout or thermal fault persists across a lockout-and-recharge cycle, the restart gives one reset pulse and then holds PWM off with the start-up source off.
- R8: pwm_en_o is never 1 in the same cycle as gate_pull_o or startup_en_o.
- R9: With the default two synchronizer stages, an input change driven between clock edges shows at the outputs after the third rising edge, and not after the second.
- R10: Priority, highest first, is lockout, then overvoltage, then brownout or thermal. Overvoltage together with brownout leads to the latched stop. Lockout together with overvoltage leads to charging, with nothing latched.
- R11: In the charging state, the start flag is ignored while the lockout flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_start_i | input | 1 | Supply above start threshold (async) |
| vcc_uvlo_i | input | 1 | Supply below lockout threshold (async) |
| vcc_ovp_i | input | 1 | Supply overvoltage (async) |
| line_ok_i | input | 1 | Line input above brownout reference (async) |
| over_temp_i | input | 1 | Die over-temperature, external hysteresis (async) |
| startup_en_o | output | 1 | Start-up current source enable |
| pwm_en_o | output | 1 | PWM switching enable |
| logic_rst_o | output | 1 | One-clock reset of internal control logic |
| gate_pull_o | output | 1 | Active gate pull-down request |

## Verification
Every state has a distinct output pattern, except the fault hold and the overvoltage latch, which both read as all-low. A wrong state therefore shows at the ports three edges after the causing input. The two all-low states can only be told apart through their release behaviour. The bench does this by clearing overvoltage and toggling the line flag and checking that PWM stays off, and by clearing a brownout and checking that PWM comes back. A lost or doubled reset pulse is caught by counting logic_rst_o cycles over each restart window.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    ST_OFF_CHG    = 3'd0,
    ST_RST_PULSE  = 3'd1,
    ST_RUN        = 3'd2,
    ST_FAULT_HOLD = 3'd3,
    ST_OVP_LATCH  = 3'd4
  } guard_state_e;

  typedef struct packed {
    logic start;
    logic uvlo;
    logic ovp;
    logic line_ok;
    logic hot;
  } guard_flags_t;

  localparam int unsigned FLAG_W = $bits(guard_flags_t);

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
  import supply_guard_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  guard_flags_t f_i,
  output guard_state_e state_o
);

  guard_state_e state_q, state_d;
  logic fault_nl;

  assign fault_nl = !f_i.line_ok || f_i.hot;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF_CHG:    if (f_i.start && !f_i.uvlo) state_d = ST_RST_PULSE;
      ST_RST_PULSE,
      ST_RUN,
      ST_FAULT_HOLD: begin
        if (f_i.uvlo)     state_d = ST_OFF_CHG;
        else if (f_i.ovp) state_d = ST_OVP_LATCH;
        else if (fault_nl) state_d = ST_FAULT_HOLD;
        else              state_d = ST_RUN;
      end
      ST_OVP_LATCH:  if (f_i.uvlo) state_d = ST_OFF_CHG;
      default:       state_d = ST_OFF_CHG;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF_CHG;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_pulse_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RST_PULSE) |=> (state_q != ST_RST_PULSE));

  assert_enter_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF_CHG && f_i.start && !f_i.uvlo) |=> (state_q == ST_RST_PULSE));

  assert_uvlo_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_i.uvlo && state_q != ST_OFF_CHG) |=> (state_q == ST_OFF_CHG));

  assert_ovp_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OVP_LATCH && !f_i.uvlo) |=> (state_q == ST_OVP_LATCH));

  assert_fault_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !f_i.uvlo && !f_i.ovp && fault_nl) |=> (state_q == ST_FAULT_HOLD));

  assert_start_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF_CHG && f_i.uvlo) |=> (state_q == ST_OFF_CHG));

endmodule

// File: rtl/guard_out_dec.sv
module guard_out_dec
  import supply_guard_pkg::*;
(
  input  guard_state_e state_i,
  output logic         startup_en_o,
  output logic         pwm_en_o,
  output logic         logic_rst_o,
  output logic         gate_pull_o
);

  always_comb begin
    startup_en_o = (state_i == ST_OFF_CHG);
    gate_pull_o  = (state_i == ST_OFF_CHG);
    logic_rst_o  = (state_i == ST_RST_PULSE);
    pwm_en_o     = (state_i == ST_RUN);
  end

  always_comb begin
    assert_pwm_excl_R8: assert (!(pwm_en_o && (gate_pull_o || startup_en_o)));
  end

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import supply_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_start_i,
  input  logic vcc_uvlo_i,
  input  logic vcc_ovp_i,
  input  logic line_ok_i,
  input  logic over_temp_i,
  output logic startup_en_o,
  output logic pwm_en_o,
  output logic logic_rst_o,
  output logic gate_pull_o
);

  guard_flags_t raw_flags, sync_flags;
  guard_state_e state;

  assign raw_flags = {vcc_start_i, vcc_uvlo_i, vcc_ovp_i, line_ok_i, over_temp_i};

  guard_sync #(
    .W      (FLAG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_flags),
    .q_o    (sync_flags)
  );

  guard_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .f_i     (sync_flags),
    .state_o (state)
  );

  guard_out_dec u_dec (
    .state_i      (state),
    .startup_en_o (startup_en_o),
    .pwm_en_o     (pwm_en_o),
    .logic_rst_o  (logic_rst_o),
    .gate_pull_o  (gate_pull_o)
  );

  assert_rst_pulse_short_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |=> !logic_rst_o);

  assert_no_pwm_in_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |-> (!pwm_en_o && !startup_en_o && !gate_pull_o));

endmodule

// File: tb/supply_guard_seq_tb.sv
`timescale 1ns/1ps
module supply_guard_seq_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic start, uvlo, ovp, lok, hot;
  logic startup_en, pwm_en, logic_rst, gate_pull;
  int total = 0;
  int bad   = 0;
  int excl_viol = 0;
  bit done = 0;

  always #4 clk = ~clk;

  supply_guard_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .vcc_start_i  (start),
    .vcc_uvlo_i   (uvlo),
    .vcc_ovp_i    (ovp),
    .line_ok_i    (lok),
    .over_temp_i  (hot),
    .startup_en_o (startup_en),
    .pwm_en_o     (pwm_en),
    .logic_rst_o  (logic_rst),
    .gate_pull_o  (gate_pull)
  );

  // R8 monitor
  always @(negedge clk) if (rst_n && pwm_en && (gate_pull || startup_en)) excl_viol++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pattern {startup_en, pwm_en, logic_rst, gate_pull}
  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {startup_en, pwm_en, logic_rst, gate_pull};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // counts reset pulses over n cycles, checking the other outputs during each pulse
  task automatic pulse_win(input int n, input int exp_cnt, input string tag);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (logic_rst) begin
        cnt++;
        check({tag, " pulse outputs"}, 4'b0010);
      end
    end
    check_int({tag, " pulse count"}, cnt, exp_cnt);
  endtask

  task automatic bring_up(input string tag);
    uvlo = 0; start = 1;
    pulse_win(6, 1, tag);
    check({tag, " run"}, 4'b0100);
    start = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; start = 0; uvlo = 1; ovp = 0; lok = 1; hot = 0;
    step(3);
    check("R1 in reset", 4'b1001);
    rst_n = 1;
    step(4);
    check("R1 after reset", 4'b1001);
  endtask

  task automatic t_start_blocked;
    start = 1; uvlo = 1;
    step(6);
    check("R11 start ignored under lockout", 4'b1001);
    start = 0;
    step(3);
  endtask

  task automatic t_startup;
    bring_up("R2 startup");
  endtask

  task automatic t_uvlo;
    uvlo = 1;
    step(4);
    check("R3 lockout", 4'b1001);
    uvlo = 0;
    step(5);
    check("R3 stays charging w/o start", 4'b1001);
    bring_up("R3 restart");
  endtask

  task automatic t_latency_brownout;
    lok = 0;
    step(2);
    check("R9 not yet after 2 edges", 4'b0100);
    step(1);
    check("R9 R5 stop after 3 edges", 4'b0000);
    step(3);
    check("R5 brownout hold", 4'b0000);
    lok = 1;
    pulse_win(5, 0, "R5 resume");
    check("R5 resumed", 4'b0100);
  endtask

  task automatic t_thermal;
    hot = 1;
    step(4);
    check("R6 thermal stop", 4'b0000);
    hot = 0;
    pulse_win(5, 0, "R6 resume");
    check("R6 resumed", 4'b0100);
  endtask

  task automatic t_ovp;
    ovp = 1;
    step(4);
    check("R4 ovp stop", 4'b0000);
    ovp = 0;
    step(6);
    check("R4 latched after clear", 4'b0000);
    lok = 0; step(4); lok = 1; step(4);
    check("R4 line toggle no release", 4'b0000);
    hot = 1; step(4); hot = 0; step(4);
    check("R4 thermal toggle no release", 4'b0000);
    uvlo = 1;
    step(4);
    check("R4 release by lockout", 4'b1001);
    bring_up("R4 restart");
  endtask

  task automatic t_cycle;
    lok = 0;
    step(4);
    check("R7 hold", 4'b0000);
    uvlo = 1;
    step(4);
    check("R7 lockout charging", 4'b1001);
    uvlo = 0; start = 1;
    pulse_win(6, 1, "R7 restart");
    check("R7 held after restart", 4'b0000);
    start = 0;
    lok = 1;
    step(4);
    check("R7 resume", 4'b0100);
  endtask

  task automatic t_priority;
    ovp = 1; lok = 0;
    step(4);
    check("R10 ovp+brownout stop", 4'b0000);
    ovp = 0; lok = 1;
    step(5);
    check("R10 ovp wins latched", 4'b0000);
    uvlo = 1;
    step(4);
    check("R10 released", 4'b1001);
    bring_up("R10 restart");
    uvlo = 1; ovp = 1;
    step(4);
    check("R10 lockout over ovp", 4'b1001);
    ovp = 0;
    step(2);
    bring_up("R10 not latched");
  endtask

  initial begin
    t_reset();
    t_start_blocked();
    t_startup();
    t_uvlo();
    t_latency_brownout();
    t_thermal();
    t_ovp();
    t_cycle();
    t_priority();
    check_int("R8 pwm exclusive", excl_viol, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule